// File: doc/BRIEF.md
# I2C Slave Address-Match Status Unit

This block listens to an I2C bus as a slave and keeps three status flags: the last received bit, a general-call flag and an address-match flag. It samples SCL and SDA through a synchronizer and detects START and STOP conditions. It counts the bits of each transfer and shifts in the first byte after every START. It then compares that byte with a programmable own-address value, in either 7-bit or 10-bit first-byte format.

A static configuration sets several things: an enable, a free-data format that skips address comparison, the 10-bit compare mode and a bit-count field giving the number of data bits per transfer. The processor side clears flags with a single-cycle strobe, which stands for a byte write to the data shift register. The block never drives the bus. Acknowledge generation, master operation and clock stretching belong to neighbouring logic.

Top module: `i2c_addr_status`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both seen after the two-flop synchronizer. SCL activity before any START changes no flag.
- R2: Data bits are sampled on SCL rising edges, most significant bit first.
- R3: The last-received-bit flag takes the final data bit of each transfer. On the acknowledge clock it then takes SDA: 0 when acknowledge was given (SDA low), 1 when it was not.
- R4: In addressing format, the general-call flag sets when the first byte after a START is all zeros. Later bytes never set it.
- R5: A START or a STOP clears the general-call flag.
- R6: With 7-bit addressing, the match flag sets when bits 7..1 of the first byte equal bits 7..1 of `own_addr`, or on a general call.
- R7: With 10-bit addressing, the match flag sets only when all 8 bits of the first byte equal `own_addr`.
- R8: A `dsr_write` pulse clears the last-received-bit and match flags and leaves the general-call flag alone. A flag being set in the same cycle takes priority over the clear.
- R9: `cfg_bit_count` selects 8 - value data bits per transfer (0 gives 8, 7 gives 1). The acknowledge clock is the rising edge right after those bits.
- R10: With `cfg_free_fmt` = 1, no comparison is made, so the general-call and match flags stay 0. The last-received-bit flag still updates.
- R11: With `cfg_enable` = 0, all bus activity is ignored and the flags hold their value.
- R12: `status` bit 0 is the last received bit, bit 1 is general call and bit 2 is address match. All other bits read 0, and every flag resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| cfg_enable | input | 1 | 1 enables bus observation |
| cfg_free_fmt | input | 1 | 1 selects free-data format (no address compare) |
| cfg_ten_bit | input | 1 | 1 selects 10-bit first-byte compare |
| cfg_bit_count | input | 3 | Data bits per transfer, 8 - value |
| own_addr | input | 8 | Slave address in bits 7..1, read/write bit in bit 0 |
| dsr_write | input | 1 | One-cycle strobe: data shift register written |
| status | output | 8 | Flags: bit 0 last bit, bit 1 general call, bit 2 match |

## Verification
A wrong bit counter or a lost transfer-active state shows up on `status` as a match flag that sets on the wrong byte. It can also show up as a last-received-bit flag that tracks a data bit where the acknowledge bit belongs. Either error appears three clocks after the SCL rising edge involved. A bad synchronizer or edge register shifts every flag update by whole cycles. The bench model compares `status` on every clock, so such a shift is caught at the first flag change. Stale general-call or match state remains visible until the next START, STOP or strobe, and the directed checks probe at exactly those points.

// File: rtl/i2c_as_pkg.sv
// Package: shared constants and configuration type for the I2C slave
// address-match status unit. Assumes byte-wide I2C transfers.
package i2c_as_pkg;
    localparam int BYTE_W    = 8;
    localparam int LRB_POS   = 0;
    localparam int GC_POS    = 1;
    localparam int MATCH_POS = 2;

    // Static configuration bundle; the enable is consumed separately.
    typedef struct packed {
        logic free_fmt;
        logic ten_bit;
    } i2c_as_cfg_t;
endpackage

// File: rtl/i2c_as_sync.sv
// Module: multi-stage synchronizer for asynchronous bus lines.
// Assumes the lines are idle-high, so every stage resets to RST_VAL.
module i2c_as_sync #(
    parameter int            STAGES  = 2,
    parameter int            W       = 2,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_as_cond.sv
// Module: bus condition detector. From synchronized SCL/SDA it flags
// START, STOP and SCL rising edges for one cycle each. Assumes the
// inputs have already been synchronized. All events are gated by enable.
module i2c_as_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev
);
    logic scl_q, sda_q;
    logic scl_held;

    // Keep the previous synchronized sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode conditions from the current and previous samples.
    always_comb begin
        scl_held = scl_s && scl_q;
        start_ev = enable && scl_held && sda_q && !sda_s;
        stop_ev  = enable && scl_held && !sda_q && sda_s;
        rise_ev  = enable && scl_s && !scl_q;
    end
endmodule

// File: rtl/i2c_as_rx.sv
// Module: transfer tracker. It counts data bits after a START, shifts
// them in MSB first, and marks the last data bit and the acknowledge
// clock. It also tracks whether the current byte is the first after a
// START. Assumes bit_count selects BYTE_W - bit_count data bits.
module i2c_as_rx #(
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(BYTE_W),
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              rise_ev,
    input  logic              sda_s,
    input  logic [SEL_W-1:0]  bit_count,
    output logic              last_ev,
    output logic              ack_ev,
    output logic              first_byte,
    output logic [BYTE_W-1:0] rx_byte
);
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  nbits;
    logic [BYTE_W-1:0] shreg;
    logic              data_ev;

    // Decode the bit position of the current SCL rising edge.
    always_comb begin
        nbits   = CNT_W'(BYTE_W) - CNT_W'(bit_count);
        data_ev = active && rise_ev && (cnt < nbits);
        last_ev = data_ev && (cnt == nbits - CNT_W'(1));
        ack_ev  = active && rise_ev && (cnt >= nbits);
        rx_byte = {shreg[BYTE_W-2:0], sda_s};
    end

    // Advance the transfer state on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active     <= 1'b0;
            cnt        <= '0;
            first_byte <= 1'b0;
            shreg      <= '0;
        end else if (start_ev) begin
            active     <= 1'b1;
            cnt        <= '0;
            first_byte <= 1'b1;
            shreg      <= '0;
        end else if (stop_ev) begin
            active     <= 1'b0;
        end else if (data_ev) begin
            shreg      <= rx_byte;
            cnt        <= cnt + CNT_W'(1);
        end else if (ack_ev) begin
            cnt        <= '0;
            first_byte <= 1'b0;
        end
    end

    // R1: a START arms a fresh first byte.
    a_r1_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && enable) |=> (active && first_byte && cnt == '0));

    // R9: the bit counter never runs past a full byte.
    a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_as_flags.sv
// Module: status flag keeper. It compares the first byte after a START
// with the own address, and holds the last-bit, general-call and match
// flags. Assumes last_ev and ack_ev are single-cycle and never coincide.
module i2c_as_flags
    import i2c_as_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  i2c_as_cfg_t       cfg,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              last_ev,
    input  logic              ack_ev,
    input  logic              first_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              sda_s,
    input  logic              dsr_write,
    output logic              lrb,
    output logic              gc,
    output logic              match
);
    logic compare_ev, is_gc, hit;

    // Address comparison on the last bit of the first byte.
    always_comb begin
        compare_ev = last_ev && first_byte && !cfg.free_fmt;
        is_gc      = (rx_byte == '0);
        if (cfg.ten_bit) hit = (rx_byte == own_addr);
        else             hit = (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) || is_gc;
    end

    // Last received bit: data bit or acknowledge level; strobe clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                lrb <= 1'b0;
        else if (last_ev || ack_ev) lrb <= sda_s;
        else if (dsr_write)        lrb <= 1'b0;
    end

    // General call flag: set by an all-zero first byte, cleared by conditions.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gc <= 1'b0;
        else if (start_ev || stop_ev)  gc <= 1'b0;
        else if (compare_ev && is_gc)  gc <= 1'b1;
    end

    // Match flag: set on a matching first byte, cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  match <= 1'b0;
        else if (compare_ev && hit)  match <= 1'b1;
        else if (dsr_write)          match <= 1'b0;
    end

    // R5: START or STOP leaves the general-call flag clear.
    a_r5_gc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> !gc);

    // R8: a strobe with no competing update clears the last-bit flag.
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_write && !last_ev && !ack_ev) |=> !lrb);

    // R10: in free-data format no compare may set the match flag.
    a_r10_free_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.free_fmt && !match) |=> !match);
endmodule

// File: rtl/i2c_addr_status.sv
// Module: top of the I2C slave address-match status unit. It wires
// the synchronizer, condition detector, transfer tracker and flag
// keeper together. Assumes configuration is static during a transfer.
module i2c_addr_status
    import i2c_as_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic                      cfg_enable,
    input  logic                      cfg_free_fmt,
    input  logic                      cfg_ten_bit,
    input  logic [$clog2(BYTE_W)-1:0] cfg_bit_count,
    input  logic [BYTE_W-1:0]         own_addr,
    input  logic                      dsr_write,
    output logic [BYTE_W-1:0]         status
);
    logic [1:0]        lines_s;
    logic              start_ev, stop_ev, rise_ev;
    logic              last_ev, ack_ev, first_byte;
    logic [BYTE_W-1:0] rx_byte;
    logic              lrb, gc, match;
    i2c_as_cfg_t       cfg;

    assign cfg = '{free_fmt: cfg_free_fmt, ten_bit: cfg_ten_bit};

    i2c_as_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) i_sync (
        .clk (clk), .rst_n (rst_n), .d ({scl_in, sda_in}), .q (lines_s)
    );

    i2c_as_cond i_cond (
        .clk (clk), .rst_n (rst_n), .enable (cfg_enable),
        .scl_s (lines_s[1]), .sda_s (lines_s[0]),
        .start_ev (start_ev), .stop_ev (stop_ev), .rise_ev (rise_ev)
    );

    i2c_as_rx #(.BYTE_W(BYTE_W)) i_rx (
        .clk (clk), .rst_n (rst_n), .enable (cfg_enable),
        .start_ev (start_ev), .stop_ev (stop_ev), .rise_ev (rise_ev),
        .sda_s (lines_s[0]), .bit_count (cfg_bit_count),
        .last_ev (last_ev), .ack_ev (ack_ev),
        .first_byte (first_byte), .rx_byte (rx_byte)
    );

    i2c_as_flags #(.BYTE_W(BYTE_W)) i_flags (
        .clk (clk), .rst_n (rst_n), .cfg (cfg), .own_addr (own_addr),
        .start_ev (start_ev), .stop_ev (stop_ev),
        .last_ev (last_ev), .ack_ev (ack_ev), .first_byte (first_byte),
        .rx_byte (rx_byte), .sda_s (lines_s[0]), .dsr_write (dsr_write),
        .lrb (lrb), .gc (gc), .match (match)
    );

    // Assemble the status word; unused bits read zero.
    always_comb begin
        status            = '0;
        status[LRB_POS]   = lrb;
        status[GC_POS]    = gc;
        status[MATCH_POS] = match;
    end

    // R11: while disabled and not strobed, the status word holds.
    a_r11_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !dsr_write) |=> $stable(status));
endmodule

// File: tb/test_i2c_addr_status.sv
`timescale 1ns/1ps
module test_i2c_addr_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       cfg_enable = 1'b1, cfg_free_fmt = 1'b0, cfg_ten_bit = 1'b0;
    logic [2:0] cfg_bit_count = 3'd0;
    logic [7:0] own_addr = 8'hA4;
    logic       dsr_write = 1'b0;
    logic [7:0] status;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_addr_status i_i2c_addr_status (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_in), .sda_in (sda_in),
        .cfg_enable (cfg_enable), .cfg_free_fmt (cfg_free_fmt),
        .cfg_ten_bit (cfg_ten_bit), .cfg_bit_count (cfg_bit_count),
        .own_addr (own_addr), .dsr_write (dsr_write), .status (status)
    );

    // Behavioural reference: line history queues plus transfer bookkeeping.
    bit scl_q[$], sda_q[$];
    bit m_act, m_first, m_lrb, m_gc, m_match;
    int m_cnt, m_sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_q = '{1, 1, 1, 1};
            sda_q = '{1, 1, 1, 1};
            m_act = 0; m_first = 0; m_lrb = 0; m_gc = 0; m_match = 0;
            m_cnt = 0; m_sh = 0;
        end else begin
            bit cs, ps, cd, pd, rise, st, sp, dat, last, ack, cmp, hit;
            int nb, byte_v;
            scl_q.push_front(scl_in); void'(scl_q.pop_back());
            sda_q.push_front(sda_in); void'(sda_q.pop_back());
            cs = scl_q[2]; ps = scl_q[3]; cd = sda_q[2]; pd = sda_q[3];
            rise = cfg_enable && cs && !ps;
            st   = cfg_enable && cs && ps && pd && !cd;
            sp   = cfg_enable && cs && ps && !pd && cd;
            nb   = 8 - int'(cfg_bit_count);
            dat  = m_act && rise && (m_cnt < nb);
            last = dat && (m_cnt == nb - 1);
            ack  = m_act && rise && (m_cnt >= nb);
            byte_v = ((m_sh * 2) + int'(cd)) % 256;
            cmp  = last && m_first && !cfg_free_fmt;
            hit  = cfg_ten_bit ? (byte_v == int'(own_addr))
                               : ((byte_v / 2) == int'(own_addr) / 2) || (byte_v == 0);
            if (last || ack) m_lrb = cd; else if (dsr_write) m_lrb = 0;
            if (st || sp) m_gc = 0; else if (cmp && byte_v == 0) m_gc = 1;
            if (cmp && hit) m_match = 1; else if (dsr_write) m_match = 0;
            if (!cfg_enable) begin
                m_act = 0; m_cnt = 0; m_first = 0; m_sh = 0;
            end else if (st) begin
                m_act = 1; m_cnt = 0; m_first = 1; m_sh = 0;
            end else if (sp) m_act = 0;
            else if (dat) begin m_sh = byte_v; m_cnt++; end
            else if (ack) begin m_cnt = 0; m_first = 0; end
        end
    end

    // Every-clock comparison against the model (R12 layout and all flags).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_s;
            exp_s = {5'b0, m_match, m_gc, m_lrb};
            checks++;
            if (status !== exp_s) begin
                errors++;
                $display("FAIL R12 model compare at %0t: actual %h expected %h", $time, status, exp_s);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] exp_s);
        checks++;
        if (status !== exp_s) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, status, exp_s);
        end
    endtask

    task automatic bus_start();
        sda_in = 1'b1; tick(4);
        scl_in = 1'b1; tick(4);
        sda_in = 1'b0; tick(4);
        scl_in = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_in = 1'b0; tick(4);
        scl_in = 1'b1; tick(4);
        sda_in = 1'b1; tick(4);
    endtask

    task automatic send_bit(logic b);
        sda_in = b;    tick(4);
        scl_in = 1'b1; tick(4);
        scl_in = 1'b0; tick(4);
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic strobe();
        dsr_write = 1'b1; tick(1);
        dsr_write = 1'b0; tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R12 reset state", 8'h00);

        // 7-bit match, MSB first, last bit then acknowledge.
        bus_start();
        send_bits(8'hA5, 8);
        chk("R6 R2 7-bit match, last bit 1", 8'h05);
        send_bit(1'b0);
        chk("R3 ack given reads 0", 8'h04);
        send_bits(8'h00, 8);
        chk("R4 zero data byte is not a general call", 8'h04);
        send_bit(1'b1);
        bus_stop();
        chk("R3 nack reads 1", 8'h05);
        strobe();
        chk("R8 strobe clears last bit and match", 8'h00);

        // 7-bit mismatch with nack.
        bus_start();
        send_bits(8'hB4, 8);
        chk("R6 mismatch leaves match clear", 8'h00);
        send_bit(1'b1);
        chk("R3 nack after mismatch", 8'h01);
        bus_stop();
        strobe();

        // General call, then clears by strobe, repeated START and STOP.
        bus_start();
        send_bits(8'h00, 8);
        send_bit(1'b0);
        chk("R4 general call sets gc and match", 8'h06);
        strobe();
        chk("R8 strobe keeps gc", 8'h02);
        bus_start();
        chk("R5 repeated START clears gc", 8'h00);
        send_bits(8'h00, 8);
        send_bit(1'b0);
        bus_stop();
        chk("R5 STOP clears gc, match stays", 8'h04);
        strobe();

        // 10-bit first-byte compare.
        cfg_ten_bit = 1'b1;
        bus_start();
        send_bits(8'hA5, 8);
        send_bit(1'b1);
        chk("R7 rw bit differs, no match", 8'h01);
        bus_start();
        send_bits(8'hA4, 8);
        send_bit(1'b0);
        chk("R7 full 8-bit agreement matches", 8'h04);
        bus_stop();
        strobe();
        cfg_ten_bit = 1'b0;

        // Free-data format.
        cfg_free_fmt = 1'b1;
        bus_start();
        send_bits(8'h00, 8);
        chk("R10 free format no general call", 8'h00);
        send_bit(1'b1);
        chk("R10 free format last bit still tracked", 8'h01);
        bus_stop();
        strobe();
        cfg_free_fmt = 1'b0;

        // Four-bit transfers: acknowledge on the fifth rising edge.
        cfg_bit_count = 3'd4;
        own_addr = 8'h04;
        bus_start();
        send_bits(8'h04, 4);
        chk("R9 4-bit first byte compared", 8'h04);
        send_bit(1'b1);
        chk("R9 fifth edge is the ack clock", 8'h05);
        bus_stop();
        strobe();
        cfg_bit_count = 3'd0;
        own_addr = 8'hA4;

        // Disabled interface ignores a general call.
        cfg_enable = 1'b0;
        bus_start();
        send_bits(8'h00, 8);
        send_bit(1'b0);
        chk("R11 disabled, no flags", 8'h00);
        bus_stop();
        cfg_enable = 1'b1;
        tick(4);

        // Clocks with no START are ignored.
        scl_in = 1'b0; tick(4);
        send_bits(8'h00, 8);
        send_bit(1'b1);
        chk("R1 no START, no flag change", 8'h00);
        sda_in = 1'b1; tick(4);
        scl_in = 1'b1; tick(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule